// File: doc/BRIEF.md
# MDIO Management Master with Register Access

This block is a station-management master for the two-wire MDC/MDIO bus that configures Ethernet PHYs. Software reaches it through a small 32-bit register bus with two words. A command word carries the operation code, the 5-bit PHY address, the 5-bit register address and 16 data bits, together with a start/busy flag and a read-failure flag. A configuration word holds the MDC clock divider, a preamble-suppress switch and a framing-select bit.

To run a transaction, software writes the command word with the start bit set. The block then generates MDC from the reference clock and shifts the management frame out on MDIO. On a read it lets go of the line for the turnaround and data phases and captures the PHY's reply. When the frame is finished the busy flag drops. After a read, the low 16 bits of the same command word hold the reply. The failure flag reports a PHY that did not pull the line low in the second turnaround bit.

The MDIO pad is exposed as separate output, output-enable and input signals, so the chip's pad ring can build the open line with its pull-up.

Top module: `mdio_master`

## Requirements
- R1: After reset, the command word reads 0x00000000 and the configuration word reads 0x00000031: framing-select bit 0 is 1, the divider in bits 9:4 is 3 and the preamble-suppress bit 12 is 0.
- R2: The command word is at byte offset 0x00 and the configuration word is at 0x04. Any other offset reads 0. The command word has busy at bit 29, read-fail at bit 28, the opcode at bits 27:26 (2 = read, 1 = write), the PHY address at bits 25:21, the register address at bits 20:16 and data at bits 15:0. Configuration fields read back as written.
- R3: A command write with bit 29 set and opcode 1 or 2 starts a frame. Bit 29 reads 1 until the frame ends and then reads 0. While bit 29 is 1, writes to either word are ignored.
- R4: MDC stays high for exactly divider+1 reference cycles in each bit, and stays low for the same number of cycles between its rising edges within a frame.
- R5: A frame with preamble has 64 MDC cycles: 32 ones, then 01, the opcode, the PHY address and the register address, MSB first. A write then sends turnaround 1,0 and the 16 data bits MSB first. MDIO changes only while MDC is low and is stable while MDC is high.
- R6: On a read, the master stops driving MDIO for both turnaround bits and all 16 data bits. It samples the line at each MDC rise, and at completion bits 15:0 of the command word hold the 16 sampled data bits, MSB first.
- R7: Bit 28 becomes 1 at the end of a read whose second turnaround bit was sampled as 1. Starting a new frame clears bit 28.
- R8: With configuration bit 12 set, the frame omits the preamble and has 32 MDC cycles, beginning with the 01 start pattern.
- R9: A command write with bit 29 set and an opcode of 0 or 3 does not start a frame: bit 29 stays 0 and MDC does not toggle.
- R10: While no frame is running, MDC is low and the MDIO output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wen | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | MDIO value driven by the master |
| mdio_oe | output | 1 | MDIO output enable; when 0 the line is released |
| mdio_in | input | 1 | MDIO line as seen at the pad |

## Verification
The bench builds the block with its default parameters: a 6-bit divider with reset value 3, a 32-bit preamble and a 4-bit address. It programs the divider to 0 and to 2, which puts full 64-bit frames within reach in a few hundred cycles and lets the MDC high time be measured at both settings. A PHY model on the bench side counts MDC rises, drives turnaround and reply bits, and records the line. This exposes frame content, preamble suppression, bus contention, the failed-turnaround case and writes made during a busy frame.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV_W    = 6,
  parameter int DIV_RST  = 3,
  parameter int PRE_BITS = 32,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wen,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mdc,
  output logic              mdio_out,
  output logic              mdio_oe,
  input  logic              mdio_in
);

  localparam int FRAME_BITS = PRE_BITS + 32;
  localparam int IDX_W      = $clog2(FRAME_BITS + 1);
  localparam int TA1        = PRE_BITS + 14;
  localparam int TA2        = PRE_BITS + 15;
  localparam int DAT0       = PRE_BITS + 16;
  localparam int LAST       = FRAME_BITS - 1;
  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  logic             busy, fail;
  logic [1:0]       op;
  logic [4:0]       phy, regad;
  logic [15:0]      data;
  logic             cfg_c22, cfg_nopre;
  logic [DIV_W-1:0] cfg_div, cnt;
  logic [IDX_W-1:0] idx;

  wire sel_cmd = reg_addr == ADDR_W'(0);
  wire sel_cfg = reg_addr == ADDR_W'(4);
  wire cmd_we  = reg_wen && sel_cmd && !busy;
  wire cfg_we  = reg_wen && sel_cfg && !busy;
  wire op_ok   = reg_wdata[27:26] == OP_RD || reg_wdata[27:26] == OP_WR;
  wire start   = cmd_we && reg_wdata[29] && op_ok;
  wire tick    = busy && cnt == cfg_div;
  wire is_rd   = op == OP_RD;

  logic unused_wbits;
  assign unused_wbits = &{1'b0, reg_wdata[31:30], reg_wdata[11:10],
                          reg_wdata[3:1], reg_wdata[31:13]};

  wire [31:0] hdr = {2'b01, op, phy, regad, is_rd ? 2'b11 : 2'b10, data};
  wire [4:0]  hpos = 5'(IDX_W'(LAST) - idx);

  assign mdio_out = busy ? ((idx < IDX_W'(PRE_BITS)) ? 1'b1 : hdr[hpos]) : 1'b1;
  assign mdio_oe  = busy && !(is_rd && idx >= IDX_W'(TA1));

  always_comb begin
    reg_rdata = 32'h0;
    if (sel_cmd)
      reg_rdata = {2'b00, busy, fail, op, phy, regad, data};
    else if (sel_cfg)
      reg_rdata = {19'h0, cfg_nopre, 2'b00, 6'(cfg_div), 3'b000, cfg_c22};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_c22   <= 1'b1;
      cfg_nopre <= 1'b0;
      cfg_div   <= DIV_W'(DIV_RST);
    end else if (cfg_we) begin
      cfg_c22   <= reg_wdata[0];
      cfg_nopre <= reg_wdata[12];
      cfg_div   <= reg_wdata[4 +: DIV_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (!busy || tick)
      cnt <= '0;
    else
      cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      fail  <= 1'b0;
      op    <= 2'b00;
      phy   <= 5'h0;
      regad <= 5'h0;
      data  <= 16'h0;
      mdc   <= 1'b0;
      idx   <= '0;
    end else if (cmd_we) begin
      op    <= reg_wdata[27:26];
      phy   <= reg_wdata[25:21];
      regad <= reg_wdata[20:16];
      data  <= reg_wdata[15:0];
      if (start) begin
        busy <= 1'b1;
        fail <= 1'b0;
        mdc  <= 1'b0;
        idx  <= cfg_nopre ? IDX_W'(PRE_BITS) : '0;
      end
    end else if (tick) begin
      if (!mdc) begin
        mdc <= 1'b1;
        if (is_rd && idx == IDX_W'(TA2))
          fail <= mdio_in != 1'b0;
        if (is_rd && idx >= IDX_W'(DAT0))
          data <= {data[14:0], mdio_in};
      end else begin
        mdc <= 1'b0;
        if (idx == IDX_W'(LAST))
          busy <= 1'b0;
        else
          idx <= idx + 1'b1;
      end
    end
  end

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc && !mdio_oe);

  assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && mdc && $past(mdc) |-> $stable(mdio_out) && $stable(mdio_oe));

  assert_half_period_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && (mdc != $past(mdc)) |-> $past(cnt) == $past(cfg_div));

  assert_busy_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(op) && $stable(phy) && $stable(regad) && $stable(cfg_div)
                            && $stable(cfg_nopre));

  assert_fail_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> op == OP_RD);

  assert_released_in_reply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy && is_rd && $past(busy) && $past(mdio_oe) && !mdio_oe |-> idx == IDX_W'(TA1));

endmodule

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_addr = 4'h0;
  logic        reg_wen = 1'b0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_out, mdio_oe;
  logic        line;

  always #10 clk = ~clk;

  mdio_master u_mdio_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wen(reg_wen),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
    .mdio_out(mdio_out), .mdio_oe(mdio_oe), .mdio_in(line)
  );

  int          n_chk = 0, n_bad = 0;
  logic        phy_rd = 1'b0, ta_ok = 1'b1;
  logic [15:0] phy_resp = 16'h0;
  int          pre = 32;
  int          rises = 0;
  logic [63:0] cap = 64'h0;
  logic        frm_clr = 1'b0;
  int          contention = 0;
  int          hcnt = 0, last_hi = 0;

  wire phy_en = phy_rd && ((rises == pre + 15 && ta_ok) ||
                           (rises >= pre + 16 && rises < pre + 32));
  wire phy_val = (rises == pre + 15) ? 1'b0
               : phy_resp[15 - ((rises - pre - 16) & 15)];
  assign line = mdio_oe ? mdio_out : (phy_en ? phy_val : 1'b1);

  always @(posedge mdc or posedge frm_clr) begin
    if (frm_clr) begin
      rises <= 0;
      cap   <= 64'h0;
    end else begin
      rises <= rises + 1;
      cap   <= {cap[62:0], line};
    end
  end

  always @(posedge clk) begin
    if (mdio_oe && phy_en) contention <= contention + 1;
    if (mdc) hcnt <= hcnt + 1;
    else if (hcnt != 0) begin
      last_hi <= hcnt;
      hcnt <= 0;
    end
  end

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wen = 1'b1;
    @(negedge clk);
    reg_wen = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    v = 32'hFFFF_FFFF;
    while (v[29]) bus_read(4'h0, v);
  endtask

  function automatic logic [31:0] cmd(input logic [1:0] o, input logic [4:0] p,
                                      input logic [4:0] r, input logic [15:0] d, input logic s);
    return {2'b00, s, 1'b0, o, p, r, d};
  endfunction

  task automatic run(input logic [31:0] c);
    frm_clr = 1'b1; #1; frm_clr = 1'b0;
    bus_write(4'h0, c & ~32'h2000_0000);
    bus_write(4'h0, c | 32'h2000_0000);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    bus_read(4'h0, v); check("R1 cmd reset", 64'(v), 64'h0);
    bus_read(4'h4, v); check("R1 cfg reset", 64'(v), 64'h31);
    bus_read(4'h8, v); check("R2 unmapped reads 0", 64'(v), 64'h0);
    check("R10 idle mdc/oe", {62'h0, mdc, mdio_oe}, 64'h0);
  endtask

  task automatic t_write();
    logic [31:0] v;
    pre = 32; phy_rd = 1'b0;
    bus_write(4'h4, 32'h1);
    bus_read(4'h4, v); check("R2 cfg readback", 64'(v), 64'h1);
    run(cmd(2'b01, 5'h05, 5'h12, 16'hA5C3, 1'b0));
    bus_read(4'h0, v); check("R3 busy during frame", 64'(v[29]), 64'h1);
    wait_idle();
    check("R5 write frame bits", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h05, 5'h12, 2'b10, 16'hA5C3});
    check("R5 write frame length", 64'(rises), 64'd64);
    check("R4 mdc high time div0", 64'(last_hi), 64'd1);
    check("R10 idle after frame", {62'h0, mdc, mdio_oe}, 64'h0);
    bus_read(4'h0, v); check("R2 cmd fields after write", 64'(v), 64'(cmd(2'b01, 5'h05, 5'h12, 16'hA5C3, 1'b0)));
  endtask

  task automatic t_fail();
    logic [31:0] v;
    pre = 32; phy_rd = 1'b1; ta_ok = 1'b0; phy_resp = 16'h1234;
    run(cmd(2'b10, 5'h02, 5'h03, 16'h0000, 1'b0));
    wait_idle();
    bus_read(4'h0, v); check("R7 read fail flag set", 64'(v[28]), 64'h1);
    phy_rd = 1'b0; ta_ok = 1'b1;
  endtask

  task automatic t_read();
    logic [31:0] v;
    pre = 32; phy_rd = 1'b1; ta_ok = 1'b1; phy_resp = 16'h796D;
    run(cmd(2'b10, 5'h1F, 5'h01, 16'hFFFF, 1'b0));
    wait_idle();
    bus_read(4'h0, v);
    check("R6 read data", 64'(v[15:0]), 64'h796D);
    check("R7 fail cleared by new frame", 64'(v[28]), 64'h0);
    check("R6 read frame on line", cap, {32'hFFFF_FFFF, 2'b01, 2'b10, 5'h1F, 5'h01, 2'b10, 16'h796D});
    check("R6 no bus contention", 64'(contention), 64'h0);
    phy_rd = 1'b0;
  endtask

  task automatic t_nopre();
    pre = 0; phy_rd = 1'b0;
    bus_write(4'h4, 32'h1001);
    run(cmd(2'b01, 5'h11, 5'h0A, 16'h0F0E, 1'b0));
    wait_idle();
    check("R8 suppressed length", 64'(rises), 64'd32);
    check("R8 suppressed frame bits", 64'(cap[31:0]), 64'({2'b01, 2'b01, 5'h11, 5'h0A, 2'b10, 16'h0F0E}));
    pre = 32;
  endtask

  task automatic t_div();
    bus_write(4'h4, 32'h21);
    run(cmd(2'b01, 5'h01, 5'h02, 16'h8001, 1'b0));
    wait_idle();
    check("R4 mdc high time div2", 64'(last_hi), 64'd3);
    check("R5 frame at div2", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h01, 5'h02, 2'b10, 16'h8001});
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    bus_write(4'h4, 32'h1);
    run(cmd(2'b01, 5'h03, 5'h04, 16'h1111, 1'b0));
    bus_write(4'h0, cmd(2'b10, 5'h1A, 5'h1B, 16'h2222, 1'b1));
    bus_write(4'h4, 32'h1031);
    wait_idle();
    bus_read(4'h0, v); check("R3 cmd write ignored while busy", 64'(v), 64'(cmd(2'b01, 5'h03, 5'h04, 16'h1111, 1'b0)));
    bus_read(4'h4, v); check("R3 cfg write ignored while busy", 64'(v), 64'h1);
    check("R3 frame unaffected", cap, {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h03, 5'h04, 2'b10, 16'h1111});
  endtask

  task automatic t_badop();
    logic [31:0] v;
    frm_clr = 1'b1; #1; frm_clr = 1'b0;
    bus_write(4'h0, cmd(2'b00, 5'h07, 5'h07, 16'h7777, 1'b1));
    bus_read(4'h0, v); check("R9 opcode 0 not started", 64'(v[29]), 64'h0);
    bus_write(4'h0, cmd(2'b11, 5'h07, 5'h07, 16'h7777, 1'b1));
    bus_read(4'h0, v); check("R9 opcode 3 not started", 64'(v[29]), 64'h0);
    repeat (20) @(negedge clk);
    check("R9 mdc did not toggle", 64'(rises), 64'h0);
    check("R10 idle after bad opcode", {62'h0, mdc, mdio_oe}, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_write();
    t_fail();
    t_read();
    t_nopre();
    t_div();
    t_busy_ignore();
    t_badop();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule